// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts a single 128-bit plaintext under a 128-bit cipher key with the AES-128 cipher. It trades throughput for area. A small controller walks one shared datapath through the rounds, and each round transformation gets a clock step of its own. Substitution goes through a 256-entry byte table with a registered read, like a block memory. The key schedule is computed on the fly, one round key per round, and uses the same table.

A pulse on `start` while the block is idle captures `key_in` and `text_in`. That capture edge also performs the initial key whitening. Ten rounds follow, each of four steps: substitute, rotate rows, mix columns, add round key. The tenth round skips the column mix. When the last step completes, `cipher_out` is loaded and `done` pulses for one cycle. The result stays on `cipher_out` until the next block completes.

Top module: `aes128_iter`

## Requirements
- R1: `cipher_out` equals the AES-128 encryption of the `text_in` and `key_in` captured at the accepted start, for any key and plaintext.
- R2: Key 000102030405060708090A0B0C0D0E0F with plaintext 00112233445566778899AABBCCDDEEFF produces 69C4E0D86A7B0430D8CDB78070B4C55A.
- R3: If `start` is sampled high at an idle rising edge, `done` is high for exactly the one cycle after the 41st rising edge, counting that sampling edge as the first. No `done` is produced otherwise.
- R4: While `rst_n` is low, `done` is 0 and `cipher_out` is all zeros.
- R5: A `start` sampled while a block is in progress is ignored, including on the edge that completes the block. The running block's result and timing are unchanged.
- R6: `cipher_out` changes only on the edge that raises `done`, and holds its value at all other times.
- R7: A `start` sampled on the edge just after the `done` cycle is accepted, so blocks can run back to back.
- R8: Byte k of the state, key and text (k = 0..15) occupies bits [127-8k:120-8k], and byte k sits in row k mod 4, column k div 4. The row step rotates row r left by r byte positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only when idle |
| key_in | input | 128 | Cipher key, sampled with an accepted start |
| text_in | input | 128 | Plaintext block, sampled with an accepted start |
| cipher_out | output | 128 | Ciphertext of the most recently completed block |
| done | output | 1 | One-cycle pulse marking a new `cipher_out` |

## Verification
The result and `done` both belong to the 41st rising edge, counting the edge that samples `start` as the first. They must be absent on every other edge. During reset the outputs are due at once. A start that arrives while busy must leave no trace at all.

The reference model in the bench advances once per rising edge from the same inputs the design saw. The bench compares `done` and `cipher_out` against it at the following falling edge, so an output that comes one edge early or late is reported. Directed sequences place ignored starts mid-block and on the completing edge, and place an accepted start in the cycle right after `done`.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUB,
    ST_SHIFT,
    ST_MIX,
    ST_ARK
  } step_e;

  // multiply by x in GF(2^8), modulus x^8+x^4+x^3+x+1
  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= aa;
      aa = xt(aa);
    end
    return acc;
  endfunction

  // table entry: inverse as x^254, then the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = x;
    e = 8'hFE;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, p);
      p = gmul(p, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  // byte k at [127-8k -: 8]; row = k%4, column = k/4
  function automatic logic [127:0] shift_rows(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] mix_columns(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

  function automatic logic [127:0] key_next(input logic [127:0] rk,
                                            input logic [31:0] sw,
                                            input logic [7:0] rc);
    logic [31:0] t, w0, w1, w2, w3;
    t  = sw ^ {rc, 24'h000000};
    w0 = rk[127:96] ^ t;
    w1 = rk[95:64] ^ w0;
    w2 = rk[63:32] ^ w1;
    w3 = rk[31:0] ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_sbox_rom.sv
module aes_sbox_rom #(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LANES*8-1:0] addr,
  output logic [LANES*8-1:0] q
);
  import aes_iter_pkg::*;

  localparam int DEPTH = 256;
  localparam int VW    = LANES * 8;

  logic [7:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = sbox_calc(8'(g));
  end

  // lane l uses the same byte slot as state byte l
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = VW - 1 - 8 * l;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[HI -: 8] <= '0;
      else if (en) q[HI -: 8] <= tbl[addr[HI -: 8]];
    end
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl #(
  parameter int ROUNDS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output aes_iter_pkg::step_e step,
  output logic                last,
  output logic                load,
  output logic                finish,
  output logic                busy
);
  import aes_iter_pkg::*;

  localparam int RW = $clog2(ROUNDS + 1);

  step_e           step_q, step_d;
  logic [RW-1:0]   round_q, round_d;

  assign step = step_q;
  assign busy = (step_q != ST_IDLE);
  assign last = (round_q == RW'(ROUNDS));

  always_comb begin
    step_d  = step_q;
    round_d = round_q;
    load    = 1'b0;
    finish  = 1'b0;
    case (step_q)
      ST_IDLE: if (start) begin
        step_d  = ST_SUB;
        round_d = RW'(1);
        load    = 1'b1;
      end
      ST_SUB:   step_d = ST_SHIFT;
      ST_SHIFT: step_d = ST_MIX;
      ST_MIX:   step_d = ST_ARK;
      ST_ARK: begin
        if (last) begin
          step_d = ST_IDLE;
          finish = 1'b1;
        end else begin
          step_d  = ST_SUB;
          round_d = round_q + RW'(1);
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_IDLE;
      round_q <= '0;
    end else begin
      step_q  <= step_d;
      round_q <= round_d;
    end
  end

endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [127:0] key_in,
  input  logic [31:0]  subw,
  output logic [127:0] rk,
  output logic [31:0]  rotw
);
  import aes_iter_pkg::*;

  logic [127:0] rk_q, rk_d;
  logic [7:0]   rc_q, rc_d;

  assign rk   = rk_q;
  assign rotw = {rk_q[23:0], rk_q[31:24]};

  always_comb begin
    rk_d = rk_q;
    rc_d = rc_q;
    if (load) begin
      rk_d = key_in;
      rc_d = 8'h01;
    end else if (adv) begin
      rk_d = key_next(rk_q, subw, rc_q);
      rc_d = xt(rc_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rk_q <= '0;
      rc_q <= '0;
    end else if (load || adv) begin
      rk_q <= rk_d;
      rc_q <= rc_d;
    end
  end

endmodule

// File: rtl/aes128_iter.sv
module aes128_iter #(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key_in,
  input  logic [127:0] text_in,
  output logic [127:0] cipher_out,
  output logic         done
);
  import aes_iter_pkg::*;

  localparam int BW = 128;

  step_e         step;
  logic          last, load, finish, busy;
  logic [BW-1:0] st_q, st_d;
  logic [BW-1:0] rk;
  logic [31:0]   rotw;
  logic [BW-1:0] sb_addr, sb_q;
  logic          sb_en;
  logic [BW-1:0] out_q;
  logic          done_q;

  aes_round_ctrl #(.ROUNDS(ROUNDS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .last(last),
    .load(load), .finish(finish), .busy(busy)
  );

  aes_key_sched i_keys (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(step == ST_MIX),
    .key_in(key_in), .subw(sb_q[BW-1 -: 32]), .rk(rk), .rotw(rotw)
  );

  // state bytes in the substitute step, rotated key word in the row step
  assign sb_addr = (step == ST_SHIFT) ? {rotw, st_q[BW-33:0]} : st_q;
  assign sb_en   = (step == ST_SUB) || (step == ST_SHIFT);

  aes_sbox_rom #(.LANES(BW / 8)) i_sbox (
    .clk(clk), .rst_n(rst_n), .en(sb_en), .addr(sb_addr), .q(sb_q)
  );

  always_comb begin
    st_d = st_q;
    if (load) st_d = text_in ^ key_in;
    else begin
      case (step)
        ST_SHIFT: st_d = shift_rows(sb_q);
        ST_MIX:   st_d = last ? st_q : mix_columns(st_q);
        ST_ARK:   st_d = st_q ^ rk;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) out_q <= st_q ^ rk;
    end
  end

  assign cipher_out = out_q;
  assign done       = done_q;

endmodule

// File: rtl/aes128_iter_chk.sv
module aes128_iter_chk #(
  parameter int ROUNDS = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] cipher_out
);
  localparam int LAT = 4 * ROUNDS + 1;
  localparam int CW  = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (start && !busy)              cnt <= CW'(1);
    else if (cnt != '0 && cnt != CW'(LAT)) cnt <= cnt + CW'(1);
    else                                  cnt <= '0;
  end

  // R3
  done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LAT)) |-> done);
  // R3
  done_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == CW'(LAT)));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt != CW'(1)));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cipher_out) |-> done);

endmodule

bind aes128_iter aes128_iter_chk #(.ROUNDS(ROUNDS)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .cipher_out(cipher_out)
);

// File: tb/test_aes128_iter.sv
`timescale 1ns/1ps
module test_aes128_iter;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] key_in, text_in;
  logic [127:0] cipher_out;
  logic         done;

  always #2 clk = ~clk;

  aes128_iter i_aes128_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .text_in(text_in), .cipher_out(cipher_out), .done(done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  bit           busy_m = 0;
  int           cnt_m = 0;
  logic [127:0] pend_m = '0;
  logic [127:0] exp_out = '0;
  bit           exp_done = 0;

  logic [7:0] sb [256];

  function automatic int gm(input int a, input int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p = p ^ a;
      a = a << 1;
      if (a & 256) a = a ^ 'h11b;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      int inv = 0;
      int v = 0;
      for (int y = 1; y < 256; y++) if (gm(x, y) == 1) inv = y;
      for (int i = 0; i < 8; i++) begin
        int bitv = ((inv >> i) ^ (inv >> ((i + 4) % 8)) ^ (inv >> ((i + 5) % 8))
                  ^ (inv >> ((i + 6) % 8)) ^ (inv >> ((i + 7) % 8)) ^ ('h63 >> i)) & 1;
        v = v | (bitv << i);
      end
      sb[x] = v[7:0];
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] k128, input logic [127:0] t128);
    logic [7:0] s [16];
    logic [7:0] k [16];
    logic [7:0] tmp [16];
    logic [7:0] w [4];
    int rc = 1;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      k[i] = k128[127-8*i -: 8];
      s[i] = t128[127-8*i -: 8] ^ k[i];
    end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int i = 0; i < 16; i++) tmp[i] = s[4*(((i/4)+(i%4))%4) + (i%4)];
      for (int i = 0; i < 16; i++) s[i] = tmp[i];
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++)
            tmp[4*c+r] = 8'(gm(s[4*c+r], 2) ^ gm(s[4*c+(r+1)%4], 3)
                            ^ s[4*c+(r+2)%4] ^ s[4*c+(r+3)%4]);
        end
        for (int i = 0; i < 16; i++) s[i] = tmp[i];
      end
      w[0] = sb[k[13]] ^ 8'(rc);
      w[1] = sb[k[14]];
      w[2] = sb[k[15]];
      w[3] = sb[k[12]];
      for (int i = 0; i < 4; i++) k[i] = k[i] ^ w[i];
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = gm(rc, 2);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, advance model at the rising edge, compare at the next falling edge
  task automatic tick(input bit s, input logic [127:0] k, input logic [127:0] t);
    start = s; key_in = k; text_in = t;
    @(posedge clk);
    if (busy_m) begin
      cnt_m++;
      if (cnt_m == 40) begin
        busy_m = 0; exp_done = 1; exp_out = pend_m;
      end else exp_done = 0;
    end else begin
      exp_done = 0;
      if (s) begin
        busy_m = 1; cnt_m = 0; pend_m = ref_enc(k, t);
      end
    end
    @(negedge clk);
    // R3 timing of done, R1 value on cipher_out, R6 hold
    check(done === exp_done, "R3 done", 128'(done), 128'(exp_done));
    check(cipher_out === exp_out, "R1/R6 cipher_out", cipher_out, exp_out);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 128'(i * 7), ~128'(i));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  localparam logic [127:0] KV_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] KV_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] KV_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] Z_CT   = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  initial begin
    build_sbox();
    rst_n = 0; start = 0; key_in = '0; text_in = '0;
    // R4: outputs cleared while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done === 1'b0, "R4 done in reset", 128'(done), 128'(0));
      check(cipher_out === '0, "R4 cipher_out in reset", cipher_out, '0);
    end
    rst_n = 1;

    // R2 known vector, R8 byte order
    tick(1, KV_KEY, KV_PT);
    idle(40);
    check(done === 1'b1 && cipher_out === KV_CT, "R2 known vector", cipher_out, KV_CT);
    idle(5);
    check(done === 1'b0 && cipher_out === KV_CT, "R6 output held", cipher_out, KV_CT);

    // R5 start mid-block ignored; R1 all-zero vector
    tick(1, '0, '0);
    idle(9);
    tick(1, KV_KEY, KV_PT);
    idle(30);
    check(done === 1'b1 && cipher_out === Z_CT, "R5 busy start ignored", cipher_out, Z_CT);

    // R5 start on completing edge ignored, R7 start just after done accepted
    begin
      logic [127:0] k1, t1, k3, t3, e3;
      k1 = rnd128(); t1 = rnd128(); k3 = rnd128(); t3 = rnd128();
      e3 = ref_enc(k3, t3);
      tick(1, k1, t1);
      idle(39);
      tick(1, rnd128(), rnd128());
      tick(1, k3, t3);
      idle(40);
      check(done === 1'b1 && cipher_out === e3, "R7 back-to-back start", cipher_out, e3);
    end

    // R1 random vectors with random gaps and stray starts
    for (int n = 0; n < 8; n++) begin
      tick(1, rnd128(), rnd128());
      for (int c = 0; c < 40 + int'($urandom % 5); c++)
        tick(($urandom % 6) == 0 && c < 39, rnd128(), rnd128());
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule